// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block holds the hazard-resolution logic of a five-stage in-order pipeline that has fetch, decode, execute, memory and write-back stages. It is purely combinational. Each cycle it looks at the register numbers and control bits held in the four inter-stage registers and at the two operand values read in decode. From these it produces three kinds of decision: which source feeds each execute-stage ALU operand, whether the front end must freeze for one cycle behind a load, and whether a branch sitting in decode is taken.

Forwarding hands a dependent instruction in execute a result that is still travelling through the memory or write-back stage, so the instruction does not wait for write-back. Load-use detection runs in decode. When it fires, the PC and the fetch/decode register hold their values and a bubble is steered into the decode/execute register. Branches are predicted not taken and are resolved in decode by comparing the two operand values read there. A taken branch costs one cycle: the wrong-path instruction in the fetch/decode register is replaced by an all-zero no-op. The datapath registers are outside the block.

Top module: `hazard_ctrl`

## Requirements
- R1: When the memory stage writes a register (memRegWrite=1) whose number memRd is nonzero and equals exRs, fwdA is 2'b10.
- R2: When only the write-back stage writes a nonzero register wbRd equal to exRs (wbRegWrite=1), fwdA is 2'b01.
- R3: When both the memory and the write-back stage match exRs, the memory stage wins and fwdA is 2'b10.
- R4: A source whose register number is 0, or whose write-enable is clear, is never forwarded, and the select stays 2'b00 (register file).
- R5: fwdB follows the same rules and codes as fwdA, with exRt in place of exRs.
- R6: When exMemRead=1, exRd is nonzero and exRd equals idRs or idRt, the outputs are pcWrEn=0, ifidWrEn=0 and bubbleSel=1.
- R7: With no load-use hazard, pcWrEn=1, ifidWrEn=1 and bubbleSel=0.
- R8: A branch in decode with idBranch=1 and idBranchNe=0 is taken when idRsVal equals idRtVal. This gives branchTaken=1 and ifidFlush=1, while pcWrEn stays 1.
- R9: With idBranch=1 and idBranchNe=1, the branch is taken when the two operand values differ.
- R10: A branch whose condition fails, or any cycle with idBranch=0, gives branchTaken=0 and ifidFlush=0.
- R11: When a branch meets a load-use stall in the same cycle, the stall wins: branchTaken=0, ifidFlush=0 and bubbleSel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs | input | REG_AW | First source register of the instruction in decode |
| idRt | input | REG_AW | Second source register of the instruction in decode |
| idRsVal | input | DATA_W | Value read for idRs |
| idRtVal | input | DATA_W | Value read for idRt |
| idBranch | input | 1 | Instruction in decode is a conditional branch |
| idBranchNe | input | 1 | Branch condition is "not equal" (0 means "equal") |
| exRs | input | REG_AW | First source register of the instruction in execute |
| exRt | input | REG_AW | Second source register of the instruction in execute |
| exRd | input | REG_AW | Destination register of the instruction in execute |
| exMemRead | input | 1 | Instruction in execute is a load |
| memRd | input | REG_AW | Destination register in the memory stage |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | REG_AW | Destination register in the write-back stage |
| wbRegWrite | input | 1 | Write-back-stage instruction writes a register |
| fwdA | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 write-back stage |
| fwdB | output | 2 | Operand B source, same encoding |
| pcWrEn | output | 1 | PC may load a new value |
| ifidWrEn | output | 1 | Fetch/decode register may load |
| bubbleSel | output | 1 | Clear the control bits entering decode/execute |
| ifidFlush | output | 1 | Load the fetch/decode register with an all-zero no-op |
| branchTaken | output | 1 | Branch in decode is taken this cycle |

## Verification
The embedded checks assume that the inputs describe a legal pipeline state: every control bit is a settled 0 or 1, and the register numbers belong to instructions that sit in consecutive stages. They say nothing about whether the stage contents are consistent with one another. For example, they do not check that exRd matches an earlier idRs. The stimulus applies one complete stage snapshot at a time and holds it for a full cycle before the outputs are sampled. It exercises each hazard alone, the overlap cases (both forwarding sources matching, and branch against load) and register 0 as a false match.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwdSel_e;

  // strobes handed from the control half to the datapath half
  typedef struct packed {
    logic stall;
    logic flush;
  } hzStrobe_t;

endpackage

// File: rtl/hz_datapath.sv
module hz_datapath
  import hz_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_AW-1:0] exRs,
  input  logic [REG_AW-1:0] exRt,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memRegWrite,
  input  logic [REG_AW-1:0] wbRd,
  input  logic              wbRegWrite,
  input  logic [DATA_W-1:0] idRsVal,
  input  logic [DATA_W-1:0] idRtVal,
  input  hzStrobe_t         strobe,
  output logic              opsEqual,
  output logic [1:0]        fwdA,
  output logic [1:0]        fwdB,
  output logic              pcWrEn,
  output logic              ifidWrEn,
  output logic              bubbleSel,
  output logic              ifidFlush
);

  localparam int                LANES    = 2;
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [REG_AW-1:0] laneReg [LANES];
  fwdSel_e           laneSel [LANES];

  assign laneReg[0] = exRs;
  assign laneReg[1] = exRt;

  // one forwarding selector per ALU operand
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic memHit;
    logic wbHit;
    always_comb begin
      memHit = memRegWrite && (memRd != ZERO_REG) && (memRd == laneReg[lane]);
      wbHit  = wbRegWrite  && (wbRd  != ZERO_REG) && (wbRd  == laneReg[lane]);
      if (memHit)     laneSel[lane] = FWD_MEM;
      else if (wbHit) laneSel[lane] = FWD_WB;
      else            laneSel[lane] = FWD_RF;
    end

    always_comb begin
      if (laneReg[lane] == ZERO_REG)
        a_r4_zero_not_forwarded: assert (laneSel[lane] == FWD_RF);
    end
  end

  assign fwdA = laneSel[0];
  assign fwdB = laneSel[1];

  // branch operand comparison in decode
  assign opsEqual = (idRsVal == idRtVal);

  // front-end steering from the control strobes
  assign pcWrEn    = !strobe.stall;
  assign ifidWrEn  = !strobe.stall;
  assign bubbleSel = strobe.stall;
  assign ifidFlush = strobe.flush;

  always_comb begin
    if (memRegWrite && wbRegWrite && memRd != ZERO_REG &&
        memRd == wbRd && memRd == exRs)
      a_r3_mem_stage_priority: assert (fwdA == FWD_MEM);
    a_r11_no_flush_during_bubble: assert (!(ifidFlush && bubbleSel));
  end

endmodule

// File: rtl/hz_control.sv
module hz_control
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] idRs,
  input  logic [REG_AW-1:0] idRt,
  input  logic              idBranch,
  input  logic              idBranchNe,
  input  logic [REG_AW-1:0] exRd,
  input  logic              exMemRead,
  input  logic              opsEqual,
  output hzStrobe_t         strobe,
  output logic              branchTaken
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic loadUse;
  logic condMet;

  always_comb begin
    loadUse = exMemRead && (exRd != ZERO_REG) &&
              ((exRd == idRs) || (exRd == idRt));
    condMet = idBranchNe ? !opsEqual : opsEqual;
    // a stalled branch is re-evaluated once the load has moved on
    branchTaken  = idBranch && condMet && !loadUse;
    strobe.stall = loadUse;
    strobe.flush = branchTaken;
  end

  always_comb begin
    if (!idBranch)
      a_r10_no_branch_no_take: assert (!branchTaken);
  end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_AW-1:0] idRs,
  input  logic [REG_AW-1:0] idRt,
  input  logic [DATA_W-1:0] idRsVal,
  input  logic [DATA_W-1:0] idRtVal,
  input  logic              idBranch,
  input  logic              idBranchNe,
  input  logic [REG_AW-1:0] exRs,
  input  logic [REG_AW-1:0] exRt,
  input  logic [REG_AW-1:0] exRd,
  input  logic              exMemRead,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memRegWrite,
  input  logic [REG_AW-1:0] wbRd,
  input  logic              wbRegWrite,
  output logic [1:0]        fwdA,
  output logic [1:0]        fwdB,
  output logic              pcWrEn,
  output logic              ifidWrEn,
  output logic              bubbleSel,
  output logic              ifidFlush,
  output logic              branchTaken
);

  hzStrobe_t strobe;
  logic      opsEqual;

  hz_control #(.REG_AW(REG_AW)) u_control (
    .idRs        (idRs),
    .idRt        (idRt),
    .idBranch    (idBranch),
    .idBranchNe  (idBranchNe),
    .exRd        (exRd),
    .exMemRead   (exMemRead),
    .opsEqual    (opsEqual),
    .strobe      (strobe),
    .branchTaken (branchTaken)
  );

  hz_datapath #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_datapath (
    .exRs        (exRs),
    .exRt        (exRt),
    .memRd       (memRd),
    .memRegWrite (memRegWrite),
    .wbRd        (wbRd),
    .wbRegWrite  (wbRegWrite),
    .idRsVal     (idRsVal),
    .idRtVal     (idRtVal),
    .strobe      (strobe),
    .opsEqual    (opsEqual),
    .fwdA        (fwdA),
    .fwdB        (fwdB),
    .pcWrEn      (pcWrEn),
    .ifidWrEn    (ifidWrEn),
    .bubbleSel   (bubbleSel),
    .ifidFlush   (ifidFlush)
  );

  always_comb begin
    if (exMemRead && exRd != '0 && exRd == idRs)
      a_r6_load_use_freezes: assert (bubbleSel && !pcWrEn && !ifidWrEn);
    if (bubbleSel)
      a_r11_stall_beats_branch: assert (!branchTaken);
    a_r8_flush_tracks_taken: assert (ifidFlush == branchTaken);
  end

endmodule

// File: tb/hazard_ctrl_bench.sv
module hazard_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int REG_AW     = 5;
  localparam int DATA_W     = 32;
  localparam int WATCHDOG   = 2000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [REG_AW-1:0] idRs, idRt, exRs, exRt, exRd, memRd, wbRd;
  logic [DATA_W-1:0] idRsVal, idRtVal;
  logic idBranch, idBranchNe, exMemRead, memRegWrite, wbRegWrite;
  logic [1:0] fwdA, fwdB;
  logic pcWrEn, ifidWrEn, bubbleSel, ifidFlush, branchTaken;

  hazard_ctrl #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_hazard_ctrl (
    .idRs(idRs), .idRt(idRt), .idRsVal(idRsVal), .idRtVal(idRtVal),
    .idBranch(idBranch), .idBranchNe(idBranchNe),
    .exRs(exRs), .exRt(exRt), .exRd(exRd), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .fwdA(fwdA), .fwdB(fwdB), .pcWrEn(pcWrEn), .ifidWrEn(ifidWrEn),
    .bubbleSel(bubbleSel), .ifidFlush(ifidFlush), .branchTaken(branchTaken)
  );

  typedef struct {
    logic [8:0] outs;   // {fwdA, fwdB, pcWrEn, ifidWrEn, bubbleSel, ifidFlush, branchTaken}
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic quiet();
    idRs = '0; idRt = '0; idRsVal = '0; idRtVal = 32'h1;
    idBranch = 0; idBranchNe = 0;
    exRs = '0; exRt = '0; exRd = '0; exMemRead = 0;
    memRd = '0; memRegWrite = 0; wbRd = '0; wbRegWrite = 0;
  endtask

  // inputs are already set by the caller; record what must come out
  task automatic expect_out(input logic [1:0] eA, input logic [1:0] eB,
                            input logic ePc, input logic eIf, input logic eBub,
                            input logic eFl, input logic eTk, input string tag);
    expItem_t it;
    it.outs = {eA, eB, ePc, eIf, eBub, eFl, eTk};
    it.tag  = tag;
    scoreQ.push_back(it);
    @(posedge clk);
  endtask

  // monitor: compare away from the edge on which inputs change
  initial begin
    forever begin
      @(negedge clk);
      if (scoreQ.size() > 0) begin
        expItem_t it;
        logic [8:0] act;
        it  = scoreQ.pop_front();
        act = {fwdA, fwdB, pcWrEn, ifidWrEn, bubbleSel, ifidFlush, branchTaken};
        checks++;
        if (act !== it.outs) begin
          fails++;
          $display("FAIL %s: outputs actual %b expected %b", it.tag, act, it.outs);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    quiet();
    @(posedge clk);
    // baseline state: nothing in flight
    expect_out(2'b00, 2'b00, 1, 1, 0, 0, 0, "R7");

    quiet(); exRs = 5'd3; memRd = 5'd3; memRegWrite = 1;
    expect_out(2'b10, 2'b00, 1, 1, 0, 0, 0, "R1");

    quiet(); exRs = 5'd4; wbRd = 5'd4; wbRegWrite = 1;
    expect_out(2'b01, 2'b00, 1, 1, 0, 0, 0, "R2");

    quiet(); exRs = 5'd5; memRd = 5'd5; memRegWrite = 1; wbRd = 5'd5; wbRegWrite = 1;
    expect_out(2'b10, 2'b00, 1, 1, 0, 0, 0, "R3");

    quiet(); exRs = 5'd0; memRd = 5'd0; memRegWrite = 1; wbRd = 5'd0; wbRegWrite = 1;
    expect_out(2'b00, 2'b00, 1, 1, 0, 0, 0, "R4");

    quiet(); exRs = 5'd6; memRd = 5'd6; wbRd = 5'd6;
    expect_out(2'b00, 2'b00, 1, 1, 0, 0, 0, "R4");

    quiet(); exRt = 5'd7; memRd = 5'd7; memRegWrite = 1; exRs = 5'd8; wbRd = 5'd8; wbRegWrite = 1;
    expect_out(2'b01, 2'b10, 1, 1, 0, 0, 0, "R5");

    quiet(); exRt = 5'd9; wbRd = 5'd9; wbRegWrite = 1;
    expect_out(2'b00, 2'b01, 1, 1, 0, 0, 0, "R5");

    quiet(); exRt = 5'd11; memRd = 5'd11; memRegWrite = 1; wbRd = 5'd11; wbRegWrite = 1;
    expect_out(2'b00, 2'b10, 1, 1, 0, 0, 0, "R5");

    quiet(); exMemRead = 1; exRd = 5'd10; idRs = 5'd10;
    expect_out(2'b00, 2'b00, 0, 0, 1, 0, 0, "R6");

    quiet(); exMemRead = 1; exRd = 5'd10; idRt = 5'd10;
    expect_out(2'b00, 2'b00, 0, 0, 1, 0, 0, "R6");

    quiet(); exMemRead = 0; exRd = 5'd10; idRs = 5'd10;
    expect_out(2'b00, 2'b00, 1, 1, 0, 0, 0, "R7");

    quiet(); exMemRead = 1; exRd = 5'd0; idRs = 5'd0;
    expect_out(2'b00, 2'b00, 1, 1, 0, 0, 0, "R6");

    quiet(); idBranch = 1; idRs = 5'd1; idRt = 5'd2; idRsVal = 32'h55; idRtVal = 32'h55;
    expect_out(2'b00, 2'b00, 1, 1, 0, 1, 1, "R8");

    quiet(); idBranch = 1; idRs = 5'd1; idRt = 5'd2; idRsVal = 32'h55; idRtVal = 32'h56;
    expect_out(2'b00, 2'b00, 1, 1, 0, 0, 0, "R10");

    quiet(); idBranch = 1; idBranchNe = 1; idRsVal = 32'h8000_0000; idRtVal = 32'h0;
    expect_out(2'b00, 2'b00, 1, 1, 0, 1, 1, "R9");

    quiet(); idBranch = 1; idBranchNe = 1; idRsVal = 32'hA5; idRtVal = 32'hA5;
    expect_out(2'b00, 2'b00, 1, 1, 0, 0, 0, "R9");

    quiet(); idBranch = 0; idRsVal = 32'h77; idRtVal = 32'h77;
    expect_out(2'b00, 2'b00, 1, 1, 0, 0, 0, "R10");

    quiet(); idBranch = 1; idRs = 5'd12; idRt = 5'd13; idRsVal = 32'h3; idRtVal = 32'h3;
    exMemRead = 1; exRd = 5'd12;
    expect_out(2'b00, 2'b00, 0, 0, 1, 0, 0, "R11");

    quiet(); idBranch = 1; idBranchNe = 1; idRs = 5'd14; idRt = 5'd13;
    idRsVal = 32'h3; idRtVal = 32'h4; exMemRead = 1; exRd = 5'd13;
    expect_out(2'b00, 2'b00, 0, 0, 1, 0, 0, "R11");

    quiet();
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule